// File: doc/BRIEF.md
# Dual Down-Counting Timer

The block holds two identical, independent down-counters. Each counter sits in its own 32-byte register window on a simple synchronous register bus. Software stores a start value, reads the live count back, and sets the counter's behaviour with one control byte. That byte selects the counting mode (free-running wrap, periodic reload or one-shot), a 16- or 32-bit width, a prescaler of 1, 16 or 256, an interrupt enable and a run enable.

When a counter steps from one to zero, it raises a raw interrupt flag. That flag, gated by the interrupt enable, drives the counter's interrupt output. A write of any data to the counter's clear address drops the flag.

A second reload path changes only the value used at the next reload and leaves the running count alone. A write to the main start register restarts the count at once. With periodic mode and a start value of all ones, the counter serves as a free-running time base that software reads inverted.

Top module: `dual_down_timer`

## Requirements
- R1: After reset every register of both counters reads zero and both interrupt outputs are low. Address bit 5 selects the counter (0 = first, 1 = second), and address bits 4:2 select the register: 0 start value, 1 live count, 2 control, 3 clear, 4 raw flag (bit 0), 5 masked flag (bit 0), 6 reload value. Read data appears on the clock edge that follows the presented address. The control register reads back its byte with bit 4 forced to zero.
- R2: A write to the start-value register (index 0) sets both the live count and the reload value to the written data in the same edge. It also restarts the prescaler, so a count already running restarts from the new value.
- R3: A write to the reload register (index 6) changes only the reload value. The live count continues undisturbed, and register index 0 then reads the new reload value.
- R4: Control bits 3:2 set the prescaler: 00 gives one decrement per clock, 01 gives one per 16 clocks, and 10 or 11 give one per 256 clocks. The first decrement lands N clocks after the edge that wrote the start value or set the run enable.
- R5: On the decrement from one to zero the raw flag is set. With control bit 6 set and bit 0 clear (periodic), the decrement after zero loads the reload value, so the sequence repeats every reload+1 decrements.
- R6: With control bits 6 and 0 both clear (free-running), a decrement from zero wraps to the all-ones value of the active width.
- R7: With control bit 0 set (one-shot, which overrides bit 6), the counter stops at zero and raises no further interrupt until it is reloaded.
- R8: With control bit 1 clear, only the low 16 bits count, wrap and reload, and the live count reads with bits 31:16 zero. With bit 1 set, all 32 bits count.
- R9: The masked flag equals the raw flag AND control bit 5, and it drives that counter's interrupt output.
- R10: A write of any data to the clear register (index 3) clears that counter's raw flag.
- R11: With control bit 7 clear, the live count holds its value.
- R12: Accesses to one counter never change the other counter's count or flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address: bit 5 counter, bits 4:2 register |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 2 | Interrupt per counter (bit 0 = first counter) |

## Verification
The in-RTL assertions check, on every cycle, these properties:
- a reload-register write never moves the count;
- a disabled counter holds;
- a stopped one-shot stays at zero without a new interrupt;
- the raw flag rises only from a one-to-zero step;
- a clear takes effect;
- the divide-by-16 prescaler never ticks on two edges in a row.

Only the bench scenarios can show the exact count values after a known number of prescaled clocks. The same holds for:
- the reload sequence in periodic mode after a reload-register change;
- 16-bit masking of odd start values;
- register readback;
- isolation between the two windows.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

  typedef struct packed {
    logic       en;
    logic       periodic;
    logic       ie;
    logic [1:0] div;
    logic       wide;
    logic       oneshot;
  } tmr_ctrl_t;

  typedef enum logic [2:0] {
    OFS_LOAD  = 3'd0,
    OFS_VALUE = 3'd1,
    OFS_CTRL  = 3'd2,
    OFS_CLR   = 3'd3,
    OFS_RAW   = 3'd4,
    OFS_MSK   = 3'd5,
    OFS_BG    = 3'd6
  } reg_ofs_e;

  function automatic tmr_ctrl_t ctrl_from_byte(input logic [7:0] b);
    tmr_ctrl_t c;
    c.en       = b[7];
    c.periodic = b[6];
    c.ie       = b[5];
    c.div      = b[3:2];
    c.wide     = b[1];
    c.oneshot  = b[0];
    return c;
  endfunction

  function automatic logic [7:0] ctrl_to_byte(input tmr_ctrl_t c);
    return {c.en, c.periodic, c.ie, 1'b0, c.div, c.wide, c.oneshot};
  endfunction

endpackage

// File: rtl/dtmr_prescaler.sv
module dtmr_prescaler #(
  parameter int LOG_MID = 4,
  parameter int LOG_MAX = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);

  logic [LOG_MAX-1:0] pcnt;
  logic               hit;

  always_comb begin
    case (sel)
      2'b00:   hit = 1'b1;
      2'b01:   hit = &pcnt[LOG_MID-1:0];
      default: hit = &pcnt;
    endcase
  end

  assign tick = run & hit;

  // cleared while stopped or on a start-value write, so the first tick lands a fixed distance away
  always_ff @(posedge clk) begin
    if (rst || !run || restart) pcnt <= '0;
    else                        pcnt <= pcnt + 1'b1;
  end

  // R4: the mid divider cannot tick on two consecutive edges
  assert_prescale_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (run && !restart && sel == 2'b01 && tick) |=> (!tick || sel == 2'b00));

endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
  import dtmr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int HALF_W  = 16,
  parameter int LOG_MID = 4,
  parameter int LOG_MAX = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_ofs,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_ofs,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);

  localparam logic [DATA_W-1:0] NARROW_MASK = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  localparam logic [DATA_W-1:0] ONE         = DATA_W'(1);

  tmr_ctrl_t         ctrl;
  logic [DATA_W-1:0] rld, cnt, mask, cur, cnt_next;
  logic              raw, tick, set_raw;
  logic              load_we, bg_we, ctrl_we, clr_we;

  assign load_we = wr_en && (wr_ofs == OFS_LOAD);
  assign bg_we   = wr_en && (wr_ofs == OFS_BG);
  assign ctrl_we = wr_en && (wr_ofs == OFS_CTRL);
  assign clr_we  = wr_en && (wr_ofs == OFS_CLR);

  assign mask = ctrl.wide ? '1 : NARROW_MASK;
  assign cur  = cnt & mask;

  dtmr_prescaler #(.LOG_MID(LOG_MID), .LOG_MAX(LOG_MAX)) u_psc (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl.en),
    .restart (load_we),
    .sel     (ctrl.div),
    .tick    (tick)
  );

  always_comb begin
    if (cur == '0 && ctrl.oneshot)       cnt_next = cur;
    else if (cur == '0 && ctrl.periodic) cnt_next = rld & mask;
    else                                 cnt_next = (cur - ONE) & mask;
  end

  assign set_raw = tick && !load_we && (cur == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      rld  <= '0;
      cnt  <= '0;
      raw  <= 1'b0;
    end else begin
      if (ctrl_we)          ctrl <= ctrl_from_byte(wr_data[7:0]);
      if (load_we || bg_we) rld  <= wr_data;
      if (load_we)          cnt  <= wr_data;
      else if (tick)        cnt  <= cnt_next;
      if (set_raw)          raw  <= 1'b1;
      else if (clr_we)      raw  <= 1'b0;
    end
  end

  always_comb begin
    case (rd_ofs)
      OFS_LOAD, OFS_BG: rd_data = rld;
      OFS_VALUE:        rd_data = cur;
      OFS_CTRL:         rd_data = DATA_W'(ctrl_to_byte(ctrl));
      OFS_RAW:          rd_data = DATA_W'(raw);
      OFS_MSK:          rd_data = DATA_W'(raw & ctrl.ie);
      default:          rd_data = '0;
    endcase
  end

  assign irq = raw & ctrl.ie;

  assert_bg_keeps_count_R3: assert property (@(posedge clk) disable iff (rst)
    (bg_we && !tick) |=> $stable(cnt));

  assert_hold_when_off_R11: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.en && !load_we) |=> $stable(cnt));

  assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrl.oneshot && cur == '0 && !load_we && !ctrl_we) |=> (cur == '0 && !$rose(raw)));

  assert_raw_source_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(raw) |-> $past(tick && cur == ONE));

  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !set_raw) |=> !raw);

endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
  import dtmr_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int DATA_W  = 32,
  parameter int HALF_W  = 16,
  parameter int WIN_LOG = 5,
  parameter int LOG_MID = 4,
  parameter int LOG_MAX = 8,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = WIN_LOG + CH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq
);

  logic [CH_W-1:0]   ch_sel;
  logic [2:0]        reg_idx;
  logic [DATA_W-1:0] ch_rd [NUM_CH];
  logic [1:0]        unused_lsb;

  assign ch_sel     = bus_addr[ADDR_W-1:WIN_LOG];
  assign reg_idx    = bus_addr[4:2];
  assign unused_lsb = bus_addr[1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dtmr_channel #(
      .DATA_W (DATA_W),
      .HALF_W (HALF_W),
      .LOG_MID(LOG_MID),
      .LOG_MAX(LOG_MAX)
    ) u_ch (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (bus_we && (ch_sel == CH_W'(g))),
      .wr_ofs  (reg_idx),
      .wr_data (bus_wdata),
      .rd_ofs  (reg_idx),
      .rd_data (ch_rd[g]),
      .irq     (irq[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= ch_rd[ch_sel];
  end

endmodule

// File: tb/dual_down_timer_test.sv
module dual_down_timer_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;

  int unsigned cyc = 0;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_down_timer uut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int ch, input int ofs, input logic [31:0] d, output int unsigned at);
    @(negedge clk);
    addr = 6'(ch * 32 + ofs * 4); we = 1'b1; wdata = d;
    @(posedge clk); #1 at = cyc;
    @(negedge clk) we = 1'b0;
  endtask

  task automatic rd(input int ch, input int ofs, output logic [31:0] v, output int unsigned at);
    @(negedge clk);
    addr = 6'(ch * 32 + ofs * 4); we = 1'b0;
    @(posedge clk); #1 at = cyc;
    @(negedge clk) v = rdata;
  endtask

  // mode: 0 free, 1 periodic, 2 one-shot
  function automatic logic [31:0] exp_val(input logic [31:0] l, input longint t, input int mode, input bit wide);
    longint m  = wide ? 64'hFFFF_FFFF : 64'hFFFF;
    longint lm = longint'(l) & m;
    case (mode)
      0:       return 32'((lm - t) & m);
      1:       return 32'(lm - (t % (lm + 1)));
      default: return (t >= lm) ? 32'd0 : 32'(lm - t);
    endcase
  endfunction

  function automatic bit exp_raw(input logic [31:0] l, input longint t, input bit wide);
    longint lm = longint'(l) & (wide ? 64'hFFFF_FFFF : 64'hFFFF);
    return (lm >= 1) && (t >= lm);
  endfunction

  function automatic longint ticks(input longint el, input int ds);
    return (ds == 0) ? el : (ds == 1) ? el / 16 : el / 256;
  endfunction

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL R1 watchdog: got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v1, L;
    int unsigned e, e2, c;
    longint t;
    int ch, mode, ds, n;
    bit wide, ie;
    logic [7:0] cfg;

    void'($urandom(32'h5EED_0804));
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rd(0, 1, v, c); chk("R1 reset count", v, 0);
    rd(0, 2, v, c); chk("R1 reset ctrl", v, 0);
    rd(1, 0, v, c); chk("R1 reset start", v, 0);
    rd(1, 4, v, c); chk("R1 reset raw", v, 0);
    chk("R1 reset irq", {30'd0, irq}, 0);

    // R1 control readback, bit 4 reads zero
    wr(1, 2, 32'h7F, e); rd(1, 2, v, c); chk("R1 ctrl readback", v, 32'h6F);
    wr(1, 2, 32'h00, e);

    // R2 restart while counting
    wr(0, 0, 32'd1000, e); wr(0, 2, 32'hC2, e);
    repeat (50) @(posedge clk);
    wr(0, 0, 32'd500, e2);
    repeat (10) @(posedge clk);
    rd(0, 1, v, c); chk("R2 restart", v, 500 - (c - 1 - e2));

    // R3 reload write leaves count alone
    wr(0, 6, 32'd7, e);
    rd(0, 1, v, c); chk("R3 count kept", v, 500 - (c - 1 - e2));
    rd(0, 0, v, c); chk("R3 start reads reload", v, 7);
    wr(0, 0, 32'd20, e); wr(0, 6, 32'd5, e2);
    rd(0, 1, v, c); t = c - 1 - e;
    chk("R3 count after reload write", v, (t <= 20) ? 32'(20 - t) : 32'(5 - ((t - 21) % 6)));
    repeat (30) @(posedge clk);
    rd(0, 1, v, c); t = c - 1 - e;
    chk("R5 periodic uses new reload", v, (t <= 20) ? 32'(20 - t) : 32'(5 - ((t - 21) % 6)));

    // R11 disabled counter holds
    wr(0, 2, 32'h42, e);
    rd(0, 1, v1, c); repeat (20) @(posedge clk);
    rd(0, 1, v, c); chk("R11 hold", v, v1);

    // R4 divide by 256 (codes 10 and 11)
    wr(1, 0, 32'd100, e); wr(1, 2, 32'h88, e);
    repeat (600) @(posedge clk);
    rd(1, 1, v, c); chk("R4 div256", v, exp_val(100, ticks(c - 1 - e, 2), 0, 0));
    wr(1, 2, 32'h00, e); wr(1, 0, 32'd100, e); wr(1, 2, 32'h8C, e);
    repeat (300) @(posedge clk);
    rd(1, 1, v, c); chk("R4 code 11", v, exp_val(100, ticks(c - 1 - e, 2), 0, 0));

    // R7 R9 R10 one-shot with interrupt enabled
    wr(0, 2, 32'h00, e); wr(0, 3, 32'h0, e); wr(0, 0, 32'd3, e); wr(0, 2, 32'hA3, e);
    repeat (10) @(posedge clk);
    rd(0, 5, v, c); chk("R9 masked set", v, 1);
    chk("R9 irq high", {31'd0, irq[0]}, 1);
    wr(0, 3, 32'hDEAD, e);
    chk("R10 irq cleared", {31'd0, irq[0]}, 0);
    rd(0, 1, v, c); chk("R7 stopped at zero", v, 0);
    repeat (10) @(posedge clk);
    rd(0, 4, v, c); chk("R7 no new interrupt", v, 0);

    // R9 interrupt enable clear
    wr(0, 2, 32'h00, e); wr(0, 0, 32'd2, e); wr(0, 2, 32'h83, e);
    repeat (8) @(posedge clk);
    rd(0, 4, v, c); chk("R9 raw set", v, 1);
    rd(0, 5, v, c); chk("R9 masked off", v, 0);
    chk("R9 irq low", {31'd0, irq[0]}, 0);

    // R12 isolation between windows
    wr(0, 2, 32'h00, e); wr(0, 3, 32'h0, e);
    wr(1, 2, 32'h00, e); wr(1, 0, 32'h1000, e); wr(1, 2, 32'h82, e);
    wr(0, 0, 32'h55, e2); wr(0, 2, 32'h82, e2); wr(0, 3, 32'h1, c);
    rd(1, 1, v, c); chk("R12 second unaffected", v, 32'h1000 - (c - 1 - e));
    rd(0, 1, v, c); chk("R12 first own count", v, 32'h55 - (c - 1 - e2));

    // R8 16-bit wrap with upper bits in the start value
    wr(0, 2, 32'h00, e); wr(0, 0, 32'hABCD_0003, e); wr(0, 2, 32'h80, e);
    rd(0, 1, v, c); chk("R8 narrow start", v, exp_val(32'hABCD_0003, c - 1 - e, 0, 0));
    repeat (10) @(posedge clk);
    rd(0, 1, v, c); chk("R8 narrow wrap", v, exp_val(32'hABCD_0003, c - 1 - e, 0, 0));

    // R6 32-bit free-running from all ones
    wr(1, 2, 32'h00, e); wr(1, 3, 32'h0, e); wr(1, 0, 32'hFFFF_FFFF, e); wr(1, 2, 32'h82, e);
    repeat (5) @(posedge clk);
    rd(1, 1, v, c); chk("R6 free from max", v, 32'hFFFF_FFFF - (c - 1 - e));
    rd(1, 4, v, c); chk("R6 no flag yet", v, 0);

    // random mix covering R4 R5 R6 R7 R8 R9
    for (int it = 0; it < 24; it++) begin
      ch   = $urandom_range(0, 1);
      mode = $urandom_range(0, 2);
      ds   = $urandom_range(0, 1);
      wide = 1'($urandom_range(0, 1));
      ie   = 1'($urandom_range(0, 1));
      L    = wide ? 32'($urandom_range(0, 40)) : {16'($urandom), 16'($urandom_range(0, 40))};
      n    = ds ? $urandom_range(0, 700) : $urandom_range(0, 90);
      cfg  = {1'b0, mode == 1, ie, 1'b0, 2'(ds), wide, mode == 2};
      wr(ch, 2, 32'(cfg), e); wr(ch, 3, 32'h0, e); wr(ch, 0, L, e);
      wr(ch, 2, 32'(cfg | 8'h80), e);
      repeat (n) @(posedge clk);
      rd(ch, 1, v, c);
      chk("R4/R5/R6/R7/R8 random count", v, exp_val(L, ticks(c - 1 - e, ds), mode, wide));
      rd(ch, 4, v, c);
      chk("R5 random raw", v, 32'(exp_raw(L, ticks(c - 1 - e, ds), wide)));
      rd(ch, 5, v, c);
      chk("R9 random masked", v, 32'(exp_raw(L, ticks(c - 1 - e, ds), wide) & ie));
      chk("R9 random irq", 32'(irq[ch]), 32'(exp_raw(L, ticks(c - e, ds), wide) & ie));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule